// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block takes a processor into an exception handler and brings it back out. It has two request ports, one for debug causes and one for all other causes. A request carries a cause code. When a request is taken, the block saves the current program counter into one of two link registers and moves the global interrupt-enable bit into the matching saved-enable bit. It then clears the global enable and issues a one-cycle redirect. The redirect target is a base address plus 32 bytes per cause code.

Two return inputs undo an entry. Each one restores the global enable from one of the saved bits and redirects to the link register of the same class. After reset, the first clock cycle issues a redirect to the normal exception base. The core's control-register path writes the global enable through a separate write port. Instruction decode, the register file, pipeline flush and the sources of the causes all stay outside this block.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held, `redirect_valid_o`, `illegal_o`, `ie_o`, `eie_o`, `bie_o`, `ea_o` and `ba_o` are all zero. On the first clock edge after release, the block issues a redirect to `exc_base_i`, which is slot 0 (the reset code, 0). Every other input is ignored in that cycle.
- R2: The debug port accepts only code 1 (breakpoint) and code 3 (watchpoint). The normal port accepts only 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) and 7 (system call). If the selected request has any other code, `illegal_o` is high for one cycle, there is no redirect, and none of the enable bits or link registers change.
- R3: A taken normal-class entry sets `ea_o` to `pc_i` and `eie_o` to the previous `ie_o`, and clears `ie_o`.
- R4: A taken debug entry sets `ba_o` to `pc_i` and `bie_o` to the previous `ie_o`, and clears `ie_o`.
- R5: The entry target is the base plus the cause code times 32, taken modulo 2^32.
- R6: A debug entry always uses `dbg_base_i`. A normal-class entry uses `dbg_base_i` when `remap_i` is 1, and `exc_base_i` otherwise.
- R7: `eret_i` copies `eie_o` into `ie_o` and redirects to `ea_o`. `bret_i` copies `bie_o` into `ie_o` and redirects to `ba_o`. Neither one changes a saved bit or a link register.
- R8: In one cycle, only one action is performed. The order of priority is: debug request, normal request, `bret_i`, `eret_i`, enable write. Lower-priority inputs in that cycle are dropped.
- R9: All outputs are registered and change at the clock edge that samples the request. `redirect_valid_o` is high for exactly the cycle after each taken entry or return, and low after any other cycle. It is never high together with `illegal_o`.
- R10: When no higher-priority action is taken, `ie_wr_i` loads `ie_wdata_i` into `ie_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | Current program counter |
| exc_base_i | input | 32 | Normal vector base |
| dbg_base_i | input | 32 | Debug vector base |
| remap_i | input | 1 | Route normal-class entries through the debug base |
| dbg_req_i | input | 1 | Debug-class exception request |
| dbg_cause_i | input | 4 | Debug cause code |
| nd_req_i | input | 1 | Normal-class exception request |
| nd_cause_i | input | 4 | Normal cause code |
| eret_i | input | 1 | Return from a normal-class exception |
| bret_i | input | 1 | Return from a debug exception |
| ie_wr_i | input | 1 | Global enable write strobe |
| ie_wdata_i | input | 1 | Global enable write value |
| redirect_valid_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| ie_o | output | 1 | Global interrupt enable |
| eie_o | output | 1 | Enable saved by a normal-class entry |
| bie_o | output | 1 | Enable saved by a debug entry |
| ea_o | output | 32 | Normal-class return address |
| ba_o | output | 32 | Debug return address |
| illegal_o | output | 1 | Illegal cause flag pulse |

## Verification
A debug entry and a normal-class entry can arrive in the same cycle, and either can also coincide with a return or an enable write. The bench drives these together in a directed cycle and in random cycles where each strobe is drawn independently. Its model lets only the highest-ranked action touch state. The bench then compares the link registers, the saved bits and the redirect target against that model, so a dropped or doubled action shows up as a wrong `ea_o`, `ba_o` or `ie_o`.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    C_RESET = 3'd0, C_BRK  = 3'd1, C_IBUS = 3'd2, C_WATCH = 3'd3,
    C_DBUS  = 3'd4, C_DIV  = 3'd5, C_IRQ  = 3'd6, C_SCALL = 3'd7
  } cause_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_RST, ACT_DBG, ACT_ND, ACT_BRET, ACT_ERET, ACT_IEWR, ACT_BAD
  } act_e;
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_seq_pkg::*;
#(
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               rst_pend_i,
  input  logic               dbg_req_i,
  input  logic [CAUSE_W-1:0] dbg_cause_i,
  input  logic               nd_req_i,
  input  logic [CAUSE_W-1:0] nd_cause_i,
  input  logic               bret_i,
  input  logic               eret_i,
  input  logic               ie_wr_i,
  output act_e               act_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic d_hi, n_hi, dbg_ok, nd_ok;
  logic [2:0] d_lo, n_lo;

  // codes above 7 are out of range when the port is wider than 3 bits
  if (CAUSE_W > 3) begin : g_hi
    assign d_hi = ~|dbg_cause_i[CAUSE_W-1:3];
    assign n_hi = ~|nd_cause_i[CAUSE_W-1:3];
  end else begin : g_nohi
    assign d_hi = 1'b1;
    assign n_hi = 1'b1;
  end

  assign d_lo   = dbg_cause_i[2:0];
  assign n_lo   = nd_cause_i[2:0];
  assign dbg_ok = d_hi && (d_lo == C_BRK || d_lo == C_WATCH);
  assign nd_ok  = n_hi && (n_lo == C_IBUS || n_lo == C_DBUS || n_lo == C_DIV ||
                           n_lo == C_IRQ  || n_lo == C_SCALL);

  always_comb begin
    act_o   = ACT_NONE;
    cause_o = dbg_req_i ? dbg_cause_i : nd_cause_i;
    if (rst_pend_i)    act_o = ACT_RST;
    else if (dbg_req_i) act_o = dbg_ok ? ACT_DBG : ACT_BAD;
    else if (nd_req_i)  act_o = nd_ok ? ACT_ND : ACT_BAD;
    else if (bret_i)    act_o = ACT_BRET;
    else if (eret_i)    act_o = ACT_ERET;
    else if (ie_wr_i)   act_o = ACT_IEWR;
  end
endmodule

// File: rtl/exc_vec.sv
module exc_vec
  import exc_seq_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CAUSE_W    = 4,
  parameter int unsigned SLOT_SHIFT = 5
) (
  input  act_e               act_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               remap_i,
  input  logic [XLEN-1:0]    exc_base_i,
  input  logic [XLEN-1:0]    dbg_base_i,
  input  logic [XLEN-1:0]    ea_i,
  input  logic [XLEN-1:0]    ba_i,
  output logic [XLEN-1:0]    tgt_o
);
  logic [XLEN-1:0] off, nd_base;

  assign off     = XLEN'(cause_i) << SLOT_SHIFT;
  assign nd_base = remap_i ? dbg_base_i : exc_base_i;

  always_comb begin
    unique case (act_i)
      ACT_RST:  tgt_o = exc_base_i;
      ACT_DBG:  tgt_o = dbg_base_i + off;
      ACT_ND:   tgt_o = nd_base + off;
      ACT_BRET: tgt_o = ba_i;
      ACT_ERET: tgt_o = ea_i;
      default:  tgt_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  act_e            act_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] tgt_i,
  input  logic            ie_wdata_i,
  output logic            rst_pend_o,
  output logic            rv_o,
  output logic [XLEN-1:0] rpc_o,
  output logic            ie_o,
  output logic            eie_o,
  output logic            bie_o,
  output logic [XLEN-1:0] ea_o,
  output logic [XLEN-1:0] ba_o,
  output logic            bad_o
);
  logic            pend_q, rv_q, ie_q, eie_q, bie_q, bad_q;
  logic [XLEN-1:0] rpc_q, ea_q, ba_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
      rv_q   <= 1'b0;
      rpc_q  <= '0;
      ie_q   <= 1'b0;
      eie_q  <= 1'b0;
      bie_q  <= 1'b0;
      ea_q   <= '0;
      ba_q   <= '0;
      bad_q  <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      rv_q   <= 1'b0;
      bad_q  <= 1'b0;
      unique case (act_i)
        ACT_RST: begin
          rv_q  <= 1'b1;
          rpc_q <= tgt_i;
        end
        ACT_DBG: begin
          ba_q  <= pc_i;
          bie_q <= ie_q;
          ie_q  <= 1'b0;
          rv_q  <= 1'b1;
          rpc_q <= tgt_i;
        end
        ACT_ND: begin
          ea_q  <= pc_i;
          eie_q <= ie_q;
          ie_q  <= 1'b0;
          rv_q  <= 1'b1;
          rpc_q <= tgt_i;
        end
        ACT_BRET: begin
          ie_q  <= bie_q;
          rv_q  <= 1'b1;
          rpc_q <= tgt_i;
        end
        ACT_ERET: begin
          ie_q  <= eie_q;
          rv_q  <= 1'b1;
          rpc_q <= tgt_i;
        end
        ACT_IEWR: ie_q  <= ie_wdata_i;
        ACT_BAD:  bad_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign rst_pend_o = pend_q;
  assign rv_o       = rv_q;
  assign rpc_o      = rpc_q;
  assign ie_o       = ie_q;
  assign eie_o      = eie_q;
  assign bie_o      = bie_q;
  assign ea_o       = ea_q;
  assign ba_o       = ba_q;
  assign bad_o      = bad_q;

  // R4
  dbg_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_DBG |=> !ie_q && bie_q == $past(ie_q) && ba_q == $past(pc_i) && rv_q);
  // R3
  nd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_ND |=> !ie_q && eie_q == $past(ie_q) && ea_q == $past(pc_i) && rv_q);
  // R2
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_BAD |=> bad_q && !rv_q && $stable(ie_q) && $stable(eie_q) &&
                         $stable(bie_q) && $stable(ea_q) && $stable(ba_q));
  // R7
  eret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_ERET |=> ie_q == $past(eie_q) && rpc_q == $past(ea_q) && $stable(eie_q));
  // R7
  bret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_BRET |=> ie_q == $past(bie_q) && rpc_q == $past(ba_q) && $stable(bie_q));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CAUSE_W    = 4,
  parameter int unsigned SLOT_BYTES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    exc_base_i,
  input  logic [XLEN-1:0]    dbg_base_i,
  input  logic               remap_i,
  input  logic               dbg_req_i,
  input  logic [CAUSE_W-1:0] dbg_cause_i,
  input  logic               nd_req_i,
  input  logic [CAUSE_W-1:0] nd_cause_i,
  input  logic               eret_i,
  input  logic               bret_i,
  input  logic               ie_wr_i,
  input  logic               ie_wdata_i,
  output logic               redirect_valid_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               ie_o,
  output logic               eie_o,
  output logic               bie_o,
  output logic [XLEN-1:0]    ea_o,
  output logic [XLEN-1:0]    ba_o,
  output logic               illegal_o
);
  localparam int unsigned SLOT_SHIFT = $clog2(SLOT_BYTES);

  act_e               act;
  logic [CAUSE_W-1:0] cause;
  logic [XLEN-1:0]    tgt;
  logic               rst_pend;

  exc_arb #(.CAUSE_W(CAUSE_W)) arb_i (
    .rst_pend_i (rst_pend),
    .dbg_req_i  (dbg_req_i),
    .dbg_cause_i(dbg_cause_i),
    .nd_req_i   (nd_req_i),
    .nd_cause_i (nd_cause_i),
    .bret_i     (bret_i),
    .eret_i     (eret_i),
    .ie_wr_i    (ie_wr_i),
    .act_o      (act),
    .cause_o    (cause)
  );

  exc_vec #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .SLOT_SHIFT(SLOT_SHIFT)) vec_i (
    .act_i     (act),
    .cause_i   (cause),
    .remap_i   (remap_i),
    .exc_base_i(exc_base_i),
    .dbg_base_i(dbg_base_i),
    .ea_i      (ea_o),
    .ba_i      (ba_o),
    .tgt_o     (tgt)
  );

  exc_state #(.XLEN(XLEN)) st_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .pc_i      (pc_i),
    .tgt_i     (tgt),
    .ie_wdata_i(ie_wdata_i),
    .rst_pend_o(rst_pend),
    .rv_o      (redirect_valid_o),
    .rpc_o     (redirect_pc_o),
    .ie_o      (ie_o),
    .eie_o     (eie_o),
    .bie_o     (bie_o),
    .ea_o      (ea_o),
    .ba_o      (ba_o),
    .bad_o     (illegal_o)
  );

  // R9
  redir_bad_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(redirect_valid_o && illegal_o));
  // R8
  dbg_over_nd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_pend && dbg_req_i && nd_req_i) |=> $stable(ea_o) && $stable(eie_o));
endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0, eb = '0, db = '0;
  logic        remap = 1'b0, dreq = 1'b0, nreq = 1'b0, bret = 1'b0, eret = 1'b0;
  logic        iewr = 1'b0, iewd = 1'b0;
  logic [3:0]  dc = '0, nc = '0;

  logic        rv, ie, eie, bie, bad;
  logic [31:0] rpc, ea, ba;

  int unsigned n_chk = 0, n_err = 0;

  bit          m_pend;
  logic        m_ie, m_eie, m_bie, e_rv, e_bad;
  logic [31:0] m_ea, m_ba, e_rpc;
  string       e_req, e_preq;

  always #2.5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .exc_base_i(eb), .dbg_base_i(db),
    .remap_i(remap), .dbg_req_i(dreq), .dbg_cause_i(dc), .nd_req_i(nreq),
    .nd_cause_i(nc), .eret_i(eret), .bret_i(bret), .ie_wr_i(iewr), .ie_wdata_i(iewd),
    .redirect_valid_o(rv), .redirect_pc_o(rpc), .ie_o(ie), .eie_o(eie), .bie_o(bie),
    .ea_o(ea), .ba_o(ba), .illegal_o(bad)
  );

  function automatic bit dbg_ok(logic [3:0] c);
    return c == 4'd1 || c == 4'd3;
  endfunction

  function automatic bit nd_ok(logic [3:0] c);
    return c == 4'd2 || c == 4'd4 || c == 4'd5 || c == 4'd6 || c == 4'd7;
  endfunction

  function automatic logic [31:0] slot(logic [31:0] base, logic [3:0] c);
    return base + ({28'd0, c} << 5);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model();
    e_rv = 1'b0; e_bad = 1'b0; e_req = "R9"; e_preq = "R5";
    if (m_pend) begin
      m_pend = 1'b0; e_rv = 1'b1; e_rpc = eb; e_req = "R1"; e_preq = "R1";
    end else if (dreq) begin
      if (!dbg_ok(dc)) begin e_bad = 1'b1; e_req = "R2"; end
      else begin
        m_ba = pc; m_bie = m_ie; m_ie = 1'b0;
        e_rv = 1'b1; e_rpc = slot(db, dc); e_req = "R4"; e_preq = "R5";
      end
    end else if (nreq) begin
      if (!nd_ok(nc)) begin e_bad = 1'b1; e_req = "R2"; end
      else begin
        m_ea = pc; m_eie = m_ie; m_ie = 1'b0;
        e_rv = 1'b1; e_rpc = slot(remap ? db : eb, nc); e_req = "R3"; e_preq = "R6";
      end
    end else if (bret) begin
      m_ie = m_bie; e_rv = 1'b1; e_rpc = m_ba; e_req = "R7"; e_preq = "R7";
    end else if (eret) begin
      m_ie = m_eie; e_rv = 1'b1; e_rpc = m_ea; e_req = "R7"; e_preq = "R7";
    end else if (iewr) begin
      m_ie = iewd; e_req = "R10";
    end
  endtask

  // caller sits just after a falling edge with inputs set
  task automatic cyc(string tag);
    string r, pr;
    model();
    r  = (tag != "") ? tag : e_req;
    pr = (tag != "") ? tag : e_preq;
    @(posedge clk);
    #1;
    chk("R9", "redirect_valid", {31'd0, rv}, {31'd0, e_rv});
    chk(r, "illegal", {31'd0, bad}, {31'd0, e_bad});
    chk(r, "ie", {31'd0, ie}, {31'd0, m_ie});
    chk(r, "eie", {31'd0, eie}, {31'd0, m_eie});
    chk(r, "bie", {31'd0, bie}, {31'd0, m_bie});
    chk(r, "ea", ea, m_ea);
    chk(r, "ba", ba, m_ba);
    if (e_rv) chk(pr, "redirect_pc", rpc, e_rpc);
    @(negedge clk);
    dreq = 1'b0; nreq = 1'b0; bret = 1'b0; eret = 1'b0; iewr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    eb = 32'h0000_1000; db = 32'h0000_8000; pc = 32'h0000_0400;
    m_pend = 1'b1; m_ie = 0; m_eie = 0; m_bie = 0; m_ea = '0; m_ba = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "redirect_valid", {31'd0, rv}, 32'd0);
    chk("R1", "illegal", {31'd0, bad}, 32'd0);
    chk("R1", "ie/eie/bie", {29'd0, ie, eie, bie}, 32'd0);
    chk("R1", "ea", ea, 32'd0);
    chk("R1", "ba", ba, 32'd0);
    rst_n = 1'b1;
    nreq = 1'b1; nc = 4'd6; iewr = 1'b1; iewd = 1'b1;   // dropped in reset-vector cycle
    cyc("R1");
    iewr = 1'b1; iewd = 1'b1; cyc("R10");
    pc = 32'h0000_2224; nreq = 1'b1; nc = 4'd6; cyc("R3");
    cyc("R9");                                           // idle: pulse must drop
    iewr = 1'b1; iewd = 1'b1; cyc("R10");
    pc = 32'h0000_3330; dreq = 1'b1; dc = 4'd3; cyc("R4");
    bret = 1'b1; cyc("R7");
    remap = 1'b1; pc = 32'h0000_4440; nreq = 1'b1; nc = 4'd7; cyc("R6");
    remap = 1'b0;
    eret = 1'b1; cyc("R7");
    dreq = 1'b1; dc = 4'd2; cyc("R2");
    nreq = 1'b1; nc = 4'd9; cyc("R2");
    nreq = 1'b1; nc = 4'd0; cyc("R2");
    iewr = 1'b1; iewd = 1'b1; cyc("R10");
    pc = 32'h0000_5550; dreq = 1'b1; dc = 4'd1; nreq = 1'b1; nc = 4'd2;
    eret = 1'b1; iewr = 1'b1; iewd = 1'b0; cyc("R8");
    nreq = 1'b1; nc = 4'd5; bret = 1'b1; cyc("R8");
    db = 32'hFFFF_FFF0; dreq = 1'b1; dc = 4'd3; cyc("R5");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) begin eb = $urandom; db = $urandom; end
      pc    = $urandom;
      remap = $urandom % 2 == 0;
      dreq  = $urandom % 5 == 0;
      dc    = ($urandom % 4 == 0) ? 4'($urandom) : (($urandom % 2 == 0) ? 4'd1 : 4'd3);
      nreq  = $urandom % 3 == 0;
      nc    = ($urandom % 4 == 0) ? 4'($urandom) : 4'(2 + 2 * ($urandom % 3) + ($urandom % 2));
      bret  = $urandom % 6 == 0;
      eret  = $urandom % 6 == 0;
      iewr  = $urandom % 3 == 0;
      iewd  = $urandom % 2 == 0;
      cyc("");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule